// File: doc/BRIEF.md
# Setpoint Ramp Controller

This block sits between a host-written setpoint (a group pulse rate or a channel duty value) and the pulse generator that uses it. It changes its output gradually instead of in one step. When a new target arrives, the effective value moves in a straight line from where it currently stands to the target. The move spreads over a programmed number of millisecond ticks, which an external strobe supplies.

The ramp length has its own register. The value in that register is copied when a target is accepted, so a ramp length written during a ramp only takes effect on the next target. A length of zero turns smoothing off: the target then goes straight to the output. To give rate and duty independent ramp lengths, instantiate one copy of the block for each setpoint.

Top module: `setpoint_ramp`

## Requirements
- R1: During a ramp of N ticks from start S to target T, the output after the k-th tick equals S + floor(|T-S|*k/N) when T>=S, or S - floor(|T-S|*k/N) when T<S. After the N-th tick the output is exactly T.
- R2: A target write while the held ramp length is 0 sets the output to the target on the next cycle, and busy stays low.
- R3: A ramp-length write during an active ramp leaves that ramp's tick count and values unchanged. The new length governs the next target write.
- R4: A target write during an active ramp starts a fresh ramp from the current output with the elapsed count reset. The output does not move in the cycle of the write.
- R5: busy rises in the cycle after a target write that differs from the output and has a nonzero ramp length. It falls in the same cycle the output reaches the target. A target equal to the current output leaves busy low.
- R6: The output holds its value on every cycle with no tick and no target write.
- R7: Reset sets the output, the target, the ramp length and busy to 0. A target written after reset with no ramp-length write therefore jumps at once.
- R8: A tick that coincides with a target write is ignored: the new ramp starts with zero elapsed ticks.
- R9: A ramp-length write in the same cycle as a target write does not apply to that target. The target uses the length held before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tgt_we | input | 1 | Target write strobe |
| tgt_in | input | VAL_W | New target value |
| rt_we | input | 1 | Ramp-length write strobe |
| rt_in | input | TIME_W | Ramp length in ticks (0 = no ramp) |
| tick_ms | input | 1 | One-cycle millisecond strobe |
| value_out | output | VAL_W | Current effective setpoint |
| busy | output | 1 | High while the output differs from the target |

## Verification
Rising and falling ramps are both exercised. Some use a span that divides evenly by the ramp length and some do not, which separates correct truncation toward the start from rounding or a sign error. Idle cycles inserted between ticks show whether the output advances only on ticks. A ramp-length write in the middle of a ramp, and one in the same cycle as a target write, show whether the length is captured at the right moment. A retarget in the middle of a ramp, a target equal to the output, and a reset in the middle of a ramp cover restart behaviour and the busy flag.

// File: rtl/srp_pkg.sv
package srp_pkg;
   typedef enum logic {SRP_UP = 1'b0, SRP_DOWN = 1'b1} srp_dir_e;
endpackage

// File: rtl/srp_time_reg.sv
module srp_time_reg #(
   parameter int TIME_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [TIME_W-1:0] din,
   output logic [TIME_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= din;
   end
endmodule

// File: rtl/srp_interp.sv
module srp_interp
   import srp_pkg::*;
#(
   parameter int VAL_W  = 16,
   parameter int TIME_W = 16
) (
   input  logic [VAL_W-1:0]  start,
   input  logic [VAL_W-1:0]  tgt,
   input  logic [TIME_W-1:0] dur,
   input  logic [TIME_W-1:0] elap,
   output logic [VAL_W-1:0]  val
);
   localparam int PW = VAL_W + TIME_W;

   srp_dir_e         dir;
   logic [VAL_W-1:0] mag;
   logic [PW-1:0]    prod;
   logic [PW-1:0]    quot;
   logic             unused_hi;

   always_comb begin
      dir  = (tgt >= start) ? SRP_UP : SRP_DOWN;
      mag  = (dir == SRP_UP) ? (tgt - start) : (start - tgt);
      prod = PW'(mag) * PW'(elap);
      quot = (dur == '0) ? PW'(mag) : (prod / PW'(dur));
      if (dir == SRP_UP) val = start + quot[VAL_W-1:0];
      else               val = start - quot[VAL_W-1:0];
   end

   assign unused_hi = ^quot[PW-1:VAL_W];
endmodule

// File: rtl/srp_seq.sv
module srp_seq #(
   parameter int VAL_W  = 16,
   parameter int TIME_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tgt_we,
   input  logic [VAL_W-1:0]  tgt_in,
   input  logic              tick,
   input  logic [TIME_W-1:0] rt_q,
   input  logic [VAL_W-1:0]  step_val,
   output logic [VAL_W-1:0]  start_q,
   output logic [VAL_W-1:0]  tgt_q,
   output logic [TIME_W-1:0] dur_q,
   output logic [TIME_W-1:0] elap_nx,
   output logic [VAL_W-1:0]  val_q,
   output logic              busy_q
);
   logic [TIME_W-1:0] elap_q;

   assign elap_nx = elap_q + TIME_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_q <= '0;
         tgt_q   <= '0;
         dur_q   <= '0;
         elap_q  <= '0;
         val_q   <= '0;
         busy_q  <= 1'b0;
      end else if (tgt_we) begin
         tgt_q   <= tgt_in;
         start_q <= val_q;
         dur_q   <= rt_q;
         elap_q  <= '0;
         if (rt_q == '0 || tgt_in == val_q) begin
            val_q  <= tgt_in;
            busy_q <= 1'b0;
         end else begin
            busy_q <= 1'b1;
         end
      end else if (busy_q && tick) begin
         elap_q <= elap_nx;
         val_q  <= step_val;
         if (elap_nx == dur_q) busy_q <= 1'b0;
      end
   end
endmodule

// File: rtl/setpoint_ramp.sv
module setpoint_ramp #(
   parameter int VAL_W  = 16,
   parameter int TIME_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tgt_we,
   input  logic [VAL_W-1:0]  tgt_in,
   input  logic              rt_we,
   input  logic [TIME_W-1:0] rt_in,
   input  logic              tick_ms,
   output logic [VAL_W-1:0]  value_out,
   output logic              busy
);
   if (VAL_W < 2 || VAL_W > 32) begin : g_bad_val
      $error("setpoint_ramp: VAL_W must be 2..32");
   end
   if (TIME_W < 1 || TIME_W > 32) begin : g_bad_time
      $error("setpoint_ramp: TIME_W must be 1..32");
   end

   logic [TIME_W-1:0] rt_q;
   logic [TIME_W-1:0] dur_q;
   logic [TIME_W-1:0] elap_nx;
   logic [VAL_W-1:0]  start_q;
   logic [VAL_W-1:0]  tgt_q;
   logic [VAL_W-1:0]  step_val;

   srp_time_reg #(.TIME_W(TIME_W)) u_time (
      .clk(clk), .rst_n(rst_n), .we(rt_we), .din(rt_in), .q(rt_q)
   );

   srp_interp #(.VAL_W(VAL_W), .TIME_W(TIME_W)) u_interp (
      .start(start_q), .tgt(tgt_q), .dur(dur_q), .elap(elap_nx), .val(step_val)
   );

   srp_seq #(.VAL_W(VAL_W), .TIME_W(TIME_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .tgt_we(tgt_we), .tgt_in(tgt_in),
      .tick(tick_ms), .rt_q(rt_q), .step_val(step_val),
      .start_q(start_q), .tgt_q(tgt_q), .dur_q(dur_q), .elap_nx(elap_nx),
      .val_q(value_out), .busy_q(busy)
   );
endmodule

// File: rtl/srp_checker.sv
module srp_checker #(
   parameter int VAL_W  = 16,
   parameter int TIME_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tgt_we,
   input logic [VAL_W-1:0]  tgt_in,
   input logic              tick_ms,
   input logic [TIME_W-1:0] rt_q,
   input logic [TIME_W-1:0] dur_q,
   input logic [VAL_W-1:0]  tgt_q,
   input logic [VAL_W-1:0]  value_out,
   input logic              busy
);
   AST_ZERO_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_we && rt_q == '0) |=> (value_out == $past(tgt_in) && !busy)); // R2
   AST_DUR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tgt_we) |=> $stable(dur_q)); // R3
   AST_RESTART_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_we && rt_q != '0 && tgt_in != value_out) |=> (busy && value_out == $past(value_out))); // R4
   AST_IDLE_ON_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (value_out == tgt_q)); // R5
   AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (!tgt_we && !tick_ms) |=> $stable(value_out)); // R6
   AST_NO_OVERSHOOT_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tgt_we && value_out <= tgt_q) |=> (value_out <= $past(tgt_q))); // R1
   AST_NO_OVERSHOOT_DN: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tgt_we && value_out >= tgt_q) |=> (value_out >= $past(tgt_q))); // R1
endmodule

bind setpoint_ramp srp_checker #(.VAL_W(VAL_W), .TIME_W(TIME_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tgt_we(tgt_we), .tgt_in(tgt_in), .tick_ms(tick_ms),
   .rt_q(rt_q), .dur_q(dur_q), .tgt_q(tgt_q), .value_out(value_out), .busy(busy)
);

// File: tb/tb_setpoint_ramp.sv
`timescale 1ns/1ps
module tb_setpoint_ramp;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tgt_we = 1'b0;
   logic [15:0] tgt_in = '0;
   logic        rt_we = 1'b0;
   logic [15:0] rt_in = '0;
   logic        tick_ms = 1'b0;
   logic [15:0] value_out;
   logic        busy;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   longint m_val, m_start, m_tgt, m_dur, m_elap, m_rt;
   bit     m_busy;

   always #2.5 clk = ~clk;

   setpoint_ramp dut (
      .clk(clk), .rst_n(rst_n), .tgt_we(tgt_we), .tgt_in(tgt_in),
      .rt_we(rt_we), .rt_in(rt_in), .tick_ms(tick_ms),
      .value_out(value_out), .busy(busy)
   );

   task automatic model_reset();
      m_val = 0; m_start = 0; m_tgt = 0; m_dur = 0; m_elap = 0; m_rt = 0; m_busy = 0;
   endtask

   function automatic longint lerp(longint s, longint t, longint k, longint n);
      longint mag;
      mag = (t >= s) ? t - s : s - t;
      return (t >= s) ? s + (mag * k) / n : s - (mag * k) / n;
   endfunction

   task automatic check(string req, longint exp_v, bit exp_b);
      checks++;
      if (value_out !== 16'(exp_v) || busy !== exp_b) begin
         fails++;
         $display("FAIL %s: value=%0d busy=%0b expected value=%0d busy=%0b",
                  req, value_out, busy, exp_v, exp_b);
      end
   endtask

   task automatic check_model(string req);
      check(req, m_val, m_busy);
   endtask

   // one clock: drive at negedge, advance past posedge, update model
   task automatic step(bit twe, longint tv, bit rwe, longint rv, bit tk);
      tgt_we = twe; tgt_in = 16'(tv); rt_we = rwe; rt_in = 16'(rv); tick_ms = tk;
      @(negedge clk);
      tgt_we = 0; rt_we = 0; tick_ms = 0;
      if (twe) begin
         m_tgt = tv;
         if (m_rt == 0 || tv == m_val) begin
            m_val = tv; m_busy = 0;
         end else begin
            m_start = m_val; m_dur = m_rt; m_elap = 0; m_busy = 1;
         end
      end else if (tk && m_busy) begin
         m_elap++;
         m_val = lerp(m_start, m_tgt, m_elap, m_dur);
         if (m_elap == m_dur) m_busy = 0;
      end
      if (rwe) m_rt = rv;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
   endtask

   task automatic do_reset();
      rst_n = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
      model_reset();
   endtask

   task automatic t_reset();
      do_reset();
      check("R7", 0, 0);
   endtask

   task automatic t_zero_bypass();
      step(1, 1000, 0, 0, 0);
      check("R2", 1000, 0);
      idle(2);
      check("R2", 1000, 0);
   endtask

   task automatic t_ramp_up();
      step(0, 0, 1, 4, 0);
      step(1, 2000, 0, 0, 0);
      check("R5", 1000, 1);
      for (int k = 1; k <= 4; k++) begin
         idle(3);
         check_model("R6");
         step(0, 0, 0, 0, 1);
         check_model("R1");
      end
      check("R1", 2000, 0);
   endtask

   task automatic t_ramp_down_uneven();
      step(0, 0, 1, 3, 0);
      step(1, 0, 0, 0, 0);
      check_model("R5");
      for (int k = 1; k <= 3; k++) begin
         step(0, 0, 0, 0, 1);
         check_model("R1");
      end
      check("R1", 0, 0);
      step(0, 0, 1, 7, 0);
      step(1, 1001, 0, 0, 0);
      for (int k = 1; k <= 7; k++) begin
         step(0, 0, 0, 0, 1);
         check_model("R1");
      end
   endtask

   task automatic t_midramp_rt();
      step(0, 0, 1, 5, 0);
      step(1, 500, 0, 0, 0);
      step(0, 0, 0, 0, 1);
      step(0, 0, 1, 2, 0);
      for (int k = 2; k <= 5; k++) begin
         step(0, 0, 0, 0, 1);
         check_model("R3");
      end
      check("R3", 500, 0);
      step(1, 900, 0, 0, 0);
      step(0, 0, 0, 0, 1);
      check("R3", 700, 1);
      step(0, 0, 0, 0, 1);
      check("R3", 900, 0);
   endtask

   task automatic t_retarget();
      step(0, 0, 1, 4, 0);
      step(1, 100, 0, 0, 0);
      step(0, 0, 0, 0, 1);
      step(0, 0, 0, 0, 1);
      check_model("R4");
      step(1, 1000, 0, 0, 0);
      check_model("R4");
      for (int k = 1; k <= 4; k++) begin
         step(0, 0, 0, 0, 1);
         check_model("R4");
      end
      check("R4", 1000, 0);
   endtask

   task automatic t_collisions();
      step(1, 3000, 0, 0, 1);
      check("R8", 1000, 1);
      step(0, 0, 0, 0, 1);
      check_model("R8");
      step(1, 0, 1, 0, 0);
      check_model("R9");
      for (int k = 1; k <= 4; k++) step(0, 0, 0, 0, 1);
      check_model("R9");
      step(1, 250, 0, 0, 0);
      check("R9", 250, 0);
   endtask

   task automatic t_equal_target();
      step(0, 0, 1, 6, 0);
      step(1, 250, 0, 0, 0);
      check("R5", 250, 0);
   endtask

   task automatic t_reset_midramp();
      step(1, 4000, 0, 0, 0);
      step(0, 0, 0, 0, 1);
      do_reset();
      check("R7", 0, 0);
      step(1, 777, 0, 0, 0);
      check("R7", 777, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: value=%0d busy=%0b expected run to complete", value_out, busy);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      model_reset();
      @(negedge clk);
      t_reset();
      t_zero_bypass();
      t_ramp_up();
      t_ramp_down_uneven();
      t_midramp_rt();
      t_retarget();
      t_collisions();
      t_equal_target();
      t_reset_midramp();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule